// File: doc/BRIEF.md
# Audio Control Register Slave (I2C, write-only)

This block is a write-only I2C target that sits between a host microcontroller and the control inputs of an audio processing path. It recovers START and STOP from the two bus lines, accepts a transfer only when the first byte equals the fixed device address, and then reads a subaddress byte. The low nibble of that byte points into a 16-entry register space. Only entries 0 to 7 are backed by storage. One bit of the subaddress turns on auto-increment of the pointer. Every byte after the subaddress is a data byte, and data bytes are stored in a bank of eight 8-bit control registers.

The registers come out in parallel on a flat bus, with register k on bits [8k+7:8k]. The bus data line is driven only through an active-high pull-down enable, which the pad turns into an open-drain low. The bank also applies one rule that links two registers: storing a bass code in the cut range, written to the tone register, clears the ALC enable in the bass-ALC register in the same update. Both bus lines go through two-flop synchronizers in the system clock domain. The system clock must run several times faster than SCL.

Top module: `audio_ctrl_regs`

## Requirements
- R1: After reset, all eight registers read 0xFE and the pull-down enable is low.
- R2: A first byte of 0x88 after START is acknowledged: `sda_pull_o` is high while SCL is high in the ninth clock.
- R3: A first byte other than 0x88 gets no acknowledge. Every later byte up to the next START is neither acknowledged nor stored.
- R4: Once the address matches, the subaddress byte and every data byte are acknowledged.
- R5: Subaddress bits 3:0 form the register pointer. Bits 7:5 have no effect.
- R6: With subaddress bit 4 clear, every data byte up to STOP is written to the same register, so the last byte wins.
- R7: With subaddress bit 4 set, the first data byte goes to the pointer and each following byte goes to the pointer plus one.
- R8: Data bytes aimed at pointers 8 to 15 are acknowledged but change no register.
- R9: During auto-increment the 4-bit pointer wraps from 15 to 0, so writing resumes at register 0.
- R10: Writing register 5 with bit 7 clear also clears bit 0 of register 7. Writing register 5 with bit 7 set leaves register 7 unchanged.
- R11: A repeated START at any point, including in the middle of a byte, drops the partial byte and restarts address reception.
- R12: The pull-down enable rises only on the SCL falling edge that ends bit 8 of an acknowledged byte. It is released on the next SCL falling edge, or on START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| regs_o | output | 64 | Register contents, register k on bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters: eight 8-bit registers, a 4-bit pointer, device address 0x88 and two synchronizer stages. With a 16-entry pointer space over eight real registers, an eleven-byte auto-increment run from pointer 6 crosses the whole discarded window and wraps back to register 0. The bench runs SCL at ten system clocks per quarter period. At that ratio the synchronizer delay never overlaps a data change, so acknowledge slots, a repeated START in the middle of a byte and the bass-to-ALC rule can each be sampled at a cycle that is known in advance.

// File: rtl/actl_pkg.sv
package actl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_SKIP
    } phase_e;

    localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/actl_bus_sync.sv
module actl_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl      = {s_q.scl[STAGES-2:0], scl_i};
        s_d.sda      = {s_q.sda[STAGES-2:0], sda_i};
        s_d.scl_prev = s_q.scl[STAGES-1];
        s_d.sda_prev = s_q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_o      = s_q.scl[STAGES-1];
    assign sda_o      = s_q.sda[STAGES-1];
    assign scl_rise_o = scl_o & ~s_q.scl_prev;
    assign scl_fall_o = ~scl_o & s_q.scl_prev;
    assign start_o    = scl_o & s_q.scl_prev & s_q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & s_q.scl_prev & ~s_q.sda_prev & sda_o;

endmodule

// File: rtl/actl_link_fsm.sv
module actl_link_fsm
    import actl_pkg::*;
#(
    parameter logic [7:0]  DEV_ADDR = 8'h88,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned SUB_W    = 4,
    parameter int unsigned INC_BIT  = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             ack_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_addr_o,
    output logic [7:0]       wr_data_o
);

    localparam logic [3:0]       BITS_FULL = 4'(BYTE_BITS);
    localparam logic [SUB_W:0]   REAL_LIM  = (SUB_W+1)'(NUM_REGS);

    typedef struct packed {
        phase_e             phase;
        logic [3:0]         bit_cnt;
        logic [7:0]         shreg;
        logic               in_ack;
        logic               ack;
        logic [SUB_W-1:0]   ptr;
        logic               inc;
        logic               wr_en;
        logic [IDX_W-1:0]   wr_addr;
        logic [7:0]         wr_data;
    } link_t;

    link_t l_d, l_q;

    always_comb begin
        l_d       = l_q;
        l_d.wr_en = 1'b0;
        if (start_det) begin
            l_d.phase   = PH_ADDR;
            l_d.bit_cnt = '0;
            l_d.in_ack  = 1'b0;
            l_d.ack     = 1'b0;
        end else if (stop_det) begin
            l_d.phase   = PH_IDLE;
            l_d.bit_cnt = '0;
            l_d.in_ack  = 1'b0;
            l_d.ack     = 1'b0;
        end else if (l_q.phase != PH_IDLE && l_q.phase != PH_SKIP) begin
            if (l_q.in_ack) begin
                if (scl_fall) begin
                    l_d.in_ack  = 1'b0;
                    l_d.ack     = 1'b0;
                    l_d.bit_cnt = '0;
                end
            end else if (scl_rise && l_q.bit_cnt != BITS_FULL) begin
                l_d.shreg   = {l_q.shreg[6:0], sda_s};
                l_d.bit_cnt = l_q.bit_cnt + 4'd1;
            end else if (scl_fall && l_q.bit_cnt == BITS_FULL) begin
                l_d.in_ack = 1'b1;
                l_d.ack    = 1'b1;
                case (l_q.phase)
                    PH_ADDR: begin
                        if (l_q.shreg == DEV_ADDR) begin
                            l_d.phase = PH_SUB;
                        end else begin
                            l_d.phase  = PH_SKIP;
                            l_d.in_ack = 1'b0;
                            l_d.ack    = 1'b0;
                        end
                    end
                    PH_SUB: begin
                        l_d.ptr   = l_q.shreg[SUB_W-1:0];
                        l_d.inc   = l_q.shreg[INC_BIT];
                        l_d.phase = PH_DATA;
                    end
                    PH_DATA: begin
                        if ({1'b0, l_q.ptr} < REAL_LIM) begin
                            l_d.wr_en   = 1'b1;
                            l_d.wr_addr = l_q.ptr[IDX_W-1:0];
                            l_d.wr_data = l_q.shreg;
                        end
                        if (l_q.inc) begin
                            l_d.ptr = l_q.ptr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q         <= '0;
            l_q.phase   <= PH_IDLE;
        end else begin
            l_q <= l_d;
        end
    end

    assign ack_o     = l_q.ack;
    assign wr_en_o   = l_q.wr_en;
    assign wr_addr_o = l_q.wr_addr;
    assign wr_data_o = l_q.wr_data;

    // R12: acknowledge starts only after a synchronized SCL fall, with SCL low
    p_ack_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_q.ack) |-> ($past(scl_fall) && !scl_s));

    // R12: acknowledge ends on SCL fall, START or STOP
    p_ack_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l_q.ack) |-> $past(scl_fall || start_det || stop_det));

    // R3: a rejected transfer never acknowledges
    p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.phase == PH_SKIP) |-> !l_q.ack);

    // R11: a START always resets to address reception
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (l_q.phase == PH_ADDR && l_q.bit_cnt == 4'd0));

endmodule

// File: rtl/actl_reg_bank.sv
module actl_reg_bank #(
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned REG_W     = 8,
    parameter logic [7:0]  RESET_VAL = 8'hFE,
    parameter int unsigned BASS_IDX  = 5,
    parameter int unsigned BASS_MSB  = 7,
    parameter int unsigned ALC_IDX   = 7,
    parameter int unsigned ALC_BIT   = 0,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    localparam logic [IDX_W-1:0] BASS_SEL = IDX_W'(BASS_IDX);

    logic [REG_W-1:0] regs_d [NUM_REGS];
    logic [REG_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (wr_en) begin
            regs_d[wr_addr] = wr_data;
            if (wr_addr == BASS_SEL && !wr_data[BASS_MSB]) begin
                regs_d[ALC_IDX][ALC_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= REG_W'(RESET_VAL);
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[g*REG_W +: REG_W] = regs_q[g];
    end

    // R10: a cut-range bass write leaves the ALC enable cleared
    p_bass_cut_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == BASS_SEL && !wr_data[BASS_MSB]) |=> !regs_q[ALC_IDX][ALC_BIT]);

    // R10: a boost-range bass write leaves the ALC register as it was
    p_bass_boost_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == BASS_SEL && wr_data[BASS_MSB]) |=> $stable(regs_q[ALC_IDX]));

    // R8: with no write strobe, register 0 holds its value
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q[0]));

endmodule

// File: rtl/audio_ctrl_regs.sv
module audio_ctrl_regs #(
    parameter logic [7:0]  DEV_ADDR    = 8'h88,
    parameter int unsigned NUM_REGS    = 8,
    parameter int unsigned REG_W       = 8,
    parameter int unsigned SUB_W       = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [7:0]  RESET_VAL   = 8'hFE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_pull_o,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [7:0]       wr_data;

    actl_bus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    actl_link_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .SUB_W    (SUB_W),
        .INC_BIT  (SUB_W)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ack_o     (sda_pull_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    actl_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .REG_W     (REG_W),
        .RESET_VAL (RESET_VAL)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data[REG_W-1:0]),
        .regs_o  (regs_o)
    );

    // R12: the pull-down never turns on while synchronized SCL is high
    p_pull_low_scl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);

endmodule

// File: tb/audio_ctrl_regs_test.sv
module audio_ctrl_regs_test;

    localparam int Q = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        pull;
    logic [63:0] regs;
    logic        sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [8];

    assign sda_line = sda_m & ~pull;

    always #2 clk = ~clk;

    audio_ctrl_regs uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (pull),
        .regs_o     (regs)
    );

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            chk8($sformatf("%s reg%0d", tag, i), regs[i*8 +: 8], model[i]);
        end
    endtask

    task automatic i2c_start();
        #Q sda_m = 1'b1;
        #Q scl_m = 1'b1;
        #(2*Q) sda_m = 1'b0;
        #(2*Q) scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        #Q sda_m = 1'b0;
        #Q scl_m = 1'b1;
        #(2*Q) sda_m = 1'b1;
        #(2*Q);
    endtask

    task automatic send_bit(input logic b);
        #Q sda_m = b;
        #Q scl_m = 1'b1;
        #(2*Q) scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i]);
        end
        #Q sda_m = 1'b1;
        #Q scl_m = 1'b1;
        #Q acked = pull;
        #Q scl_m = 1'b0;
    endtask

    // R1
    task automatic t_reset();
        chk1("R1 pull after reset", pull, 1'b0);
        chk_all("R1 reset value");
    endtask

    // R2, R4, R12
    task automatic t_single();
        logic a;
        i2c_start();
        send_byte(8'h88, a); chk1("R2 address ack", a, 1'b1);
        #Q chk1("R12 pull released after ack clock", pull, 1'b0);
        send_byte(8'h02, a); chk1("R4 subaddress ack", a, 1'b1);
        send_byte(8'h5A, a); chk1("R4 data ack", a, 1'b1);
        i2c_stop();
        model[2] = 8'h5A;
        chk_all("R4 single write");
    endtask

    // R6
    task automatic t_same();
        logic a;
        i2c_start();
        send_byte(8'h88, a);
        send_byte(8'h03, a);
        send_byte(8'h11, a); chk1("R6 data1 ack", a, 1'b1);
        send_byte(8'h22, a);
        send_byte(8'h33, a); chk1("R6 data3 ack", a, 1'b1);
        i2c_stop();
        model[3] = 8'h33;
        chk_all("R6 no increment");
    endtask

    // R5
    task automatic t_dontcare();
        logic a;
        i2c_start();
        send_byte(8'h88, a);
        send_byte(8'hE1, a);
        send_byte(8'h6C, a);
        send_byte(8'h6D, a);
        i2c_stop();
        model[1] = 8'h6D;
        chk_all("R5 upper bits ignored");
    endtask

    // R7
    task automatic t_incr();
        logic a;
        i2c_start();
        send_byte(8'h88, a);
        send_byte(8'h10, a);
        for (int k = 0; k < 4; k++) begin
            send_byte(8'(k + 1), a);
            model[k] = 8'(k + 1);
        end
        i2c_stop();
        chk_all("R7 auto increment");
    endtask

    // R8, R9
    task automatic t_wrap();
        logic a;
        i2c_start();
        send_byte(8'h88, a);
        send_byte(8'h16, a);
        for (int k = 0; k < 11; k++) begin
            send_byte(8'hA0 + 8'(k), a);
            chk1($sformatf("R8 ack byte %0d", k), a, 1'b1);
        end
        i2c_stop();
        model[6] = 8'hA0;
        model[7] = 8'hA1;
        model[0] = 8'hAA;
        chk_all("R9 wrap after discarded range");
    endtask

    // R10
    task automatic t_bass();
        logic a;
        i2c_start();
        send_byte(8'h88, a); send_byte(8'h07, a); send_byte(8'hFF, a);
        i2c_stop();
        i2c_start();
        send_byte(8'h88, a); send_byte(8'h05, a); send_byte(8'h70, a);
        i2c_stop();
        model[5] = 8'h70;
        model[7] = 8'hFE;
        chk_all("R10 cut clears ALC");
        i2c_start();
        send_byte(8'h88, a); send_byte(8'h07, a); send_byte(8'hFF, a);
        i2c_stop();
        i2c_start();
        send_byte(8'h88, a); send_byte(8'h05, a); send_byte(8'h9A, a);
        i2c_stop();
        model[5] = 8'h9A;
        model[7] = 8'hFF;
        chk_all("R10 boost keeps ALC");
    endtask

    // R3
    task automatic t_mismatch();
        logic a;
        i2c_start();
        send_byte(8'h8A, a); chk1("R3 wrong address no ack", a, 1'b0);
        send_byte(8'h00, a); chk1("R3 ignored sub no ack", a, 1'b0);
        send_byte(8'h77, a); chk1("R3 ignored data no ack", a, 1'b0);
        i2c_stop();
        chk_all("R3 ignored transfer");
    endtask

    // R11
    task automatic t_restart();
        logic a;
        i2c_start();
        send_byte(8'h88, a); send_byte(8'h01, a); send_byte(8'h44, a);
        i2c_start();
        send_byte(8'h88, a); chk1("R11 address after repeated start", a, 1'b1);
        send_byte(8'h02, a); send_byte(8'h66, a);
        i2c_stop();
        model[1] = 8'h44;
        model[2] = 8'h66;
        chk_all("R11 repeated start");
        i2c_start();
        send_byte(8'h88, a); send_byte(8'h03, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        i2c_start();
        send_byte(8'h88, a); chk1("R11 address after mid-byte start", a, 1'b1);
        send_byte(8'h04, a); send_byte(8'h12, a);
        i2c_stop();
        model[4] = 8'h12;
        chk_all("R11 mid-byte restart");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'hFE;
        #1;
        #20 rst_n = 1'b1;
        #Q;
        t_reset();
        t_single();
        t_same();
        t_dontcare();
        t_incr();
        t_wrap();
        t_bass();
        t_mismatch();
        t_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule